// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns one 64-bit virtual address into a physical address for a single outstanding request. It first screens the address: an address whose upper bits are not a faithful sign extension is refused, and an address inside the kernel superpage window is mapped directly with no memory traffic. Every other address is resolved by walking a three-level page table. Each level is fetched through a single 64-bit read port whose response may arrive any number of cycles after the request.

A request carries the address, the access kind, the privilege mode and the byte address of the first-level table. The block answers with a one-cycle `done` pulse. Alongside the pulse it gives either a physical address and a read/write/execute grant mask, or a fault code with the faulting address and an access indicator. The leaf entry grants rights per privilege mode. Separate fault-on bits in the leaf can then withdraw rights that were granted, and a failure caused that way is reported with its own code.

Top module: `pt_walker`

## Requirements
- R1: An address whose bits 63 down to VA_BITS (default 43) are not all equal to bit 63 finishes with fault code 1 (access violation), and no memory read is issued.
- R2: A well-formed address with bit 63 set and bits 42:41 equal to 2'b10, requested in kernel mode (`req_user`=0), succeeds with no memory read. The physical address has virtual bits 39:0 in bits 39:0, virtual bit 40 in bit 43, and zero elsewhere. The grant mask is 3'b111.
- R3: A superpage address requested in user mode (`req_user`=1) finishes with fault code 1.
- R4: The walk reads level 1 at `req_ptbr` + 8*va[42:33], level 2 at base2 + 8*va[32:23] and level 3 at base3 + 8*va[22:13]. Each next base is the entry's bits 63:32 shifted left by 13. On success `paddr` is (leaf bits 63:32) << 13 OR'd with va[12:0].
- R5: An entry with bit 0 (valid) clear, at any level, ends the walk at once with fault code 2 (not valid). No further level is read.
- R6: A valid level-1 or level-2 entry with bit 8 (kernel read enable) clear ends the walk with fault code 1.
- R7: In the leaf, bit 8+mode grants read and execute, and bit 12+mode grants write. The grant mask `perm` has bit 0 = read, bit 1 = write and bit 2 = execute.
- R8: Access kind 0 (read) needs read, 1 (write) needs write and 2 (fetch) needs execute. If the leaf grant lacks the needed right, the result is fault code 1.
- R9: After that check, leaf bits 1, 2 and 3 remove read, write and execute from the grant. A need that is then unmet gives code 5 (fetch), 4 (write) or 3 (read), chosen in that priority order. On success `perm` is the reduced grant.
- R10: Access kind 3 (probe) needs no right. With a valid walk it always succeeds and reports the reduced grant, even when that grant is empty.
- R11: On a fault `ok` is 0, `paddr` and `perm` are 0, `fault_va` is the request address and `fault_acc` is 2'b11 for a fetch, 2'b01 for a write and 2'b00 otherwise. On success `ok` is 1 and the code is 0.
- R12: `busy` rises on the cycle after a request is accepted and falls as the single-cycle `done` pulse rises. A `req_valid` seen while busy is ignored.
- R13: Results do not depend on the memory latency. The walker holds in each level until `mem_valid` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_vaddr | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 probe |
| req_user | input | 1 | Privilege mode index: 0 kernel, 1 user |
| req_ptbr | input | 64 | Byte address of the level-1 table |
| busy | output | 1 | A request is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Byte address of the entry read |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Translation succeeded |
| paddr | output | 64 | Physical address |
| perm | output | 3 | Grant mask: bit0 read, bit1 write, bit2 execute |
| fault_code | output | 3 | 0 none, 1 access, 2 not valid, 3/4/5 fault-on read/write/execute |
| fault_va | output | 64 | Faulting virtual address |
| fault_acc | output | 2 | Fault access indicator |

## Verification
The hardest cases to reach are the fault-on cases. In these the leaf must pass the rights check and then lose the needed right, so the table must hold a leaf that grants a right and also sets the matching fault-on bit. The bench builds its table in a sparse memory model with such leaves next to plain ones. It requests the same page once with the affected access kind and once with a different kind, which separates the rights check from the fault-on check. A stray request is injected in the middle of a slow walk to show that it leaves the result unchanged.

// File: rtl/pt_walker_pkg.sv
// Shared encodings for the page table walker: access kinds, fault codes
// and entry bit positions. Assumes the mode index is 0 or 1.
package pt_walker_pkg;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_TNV  = 3'd2,
        FLT_FOR  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_FOE  = 3'd5
    } flt_e;

    localparam logic [1:0] ACC_RD    = 2'd0;
    localparam logic [1:0] ACC_WR    = 2'd1;
    localparam logic [1:0] ACC_EX    = 2'd2;

    localparam int E_VALID = 0;
    localparam int E_FO_LO = 1;
    localparam int E_RD_LO = 8;
    localparam int E_WR_LO = 12;

    // Right needed by an access kind: bit0 read, bit1 write, bit2 execute
    function automatic logic [2:0] need_of(input logic [1:0] acc);
        case (acc)
            ACC_RD:  need_of = 3'b001;
            ACC_WR:  need_of = 3'b010;
            ACC_EX:  need_of = 3'b100;
            default: need_of = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/pt_addr_screen.sv
// Address screen: flags a malformed sign extension and detects the
// kernel superpage window, producing its direct physical mapping.
// Purely combinational; assumes VA_BITS is at least 43.
module pt_addr_screen #(
    parameter int VA_BITS = 43
) (
    input  logic [63:0] va,
    output logic        sign_bad,
    output logic        super_hit,
    output logic [63:0] super_pa
);
    localparam int HI_W = 64 - VA_BITS;

    // Upper bits must all repeat bit 63
    always_comb sign_bad = (va[63:VA_BITS] != {HI_W{va[63]}});

    // Negative address with window select 2'b10
    always_comb super_hit = va[63] && (va[42:41] == 2'b10);

    // Low 40 bits pass through, bit 40 relocates to bit 43
    always_comb super_pa = {20'd0, va[40], 3'd0, va[39:0]};
endmodule

// File: rtl/pt_leaf_eval.sv
// Leaf rights evaluation: grants rights from the per-mode enable bits,
// checks the need, then strips rights through the fault-on bits.
// Purely combinational; the entry is assumed valid.
module pt_leaf_eval
    import pt_walker_pkg::*;
(
    input  logic [63:0] pte,
    input  logic        user,
    input  logic [2:0]  need,
    output flt_e        code,
    output logic [2:0]  perm
);
    logic [2:0] grant;
    logic [2:0] trimmed;

    // Rights granted to this mode: read and execute share one enable
    always_comb begin
        grant[0] = pte[E_RD_LO + int'(user)];
        grant[2] = pte[E_RD_LO + int'(user)];
        grant[1] = pte[E_WR_LO + int'(user)];
    end

    // Fault-on bits 1..3 withdraw read, write and execute
    always_comb trimmed = grant & ~pte[E_FO_LO +: 3];

    // Rights check first, then fault-on check in execute/write/read order
    always_comb begin
        code = FLT_NONE;
        perm = trimmed;
        if (need != 3'b000 && (grant & need) == 3'b000) begin
            code = FLT_ACV;
            perm = 3'b000;
        end else if (need != 3'b000 && (trimmed & need) == 3'b000) begin
            perm = 3'b000;
            if (need[2])      code = FLT_FOE;
            else if (need[1]) code = FLT_FOW;
            else              code = FLT_FOR;
        end
    end
endmodule

// File: rtl/pt_walker.sv
// Page table walker top: accepts one request, screens the address,
// walks LEVELS table levels through a variable-latency read port and
// reports a physical address with rights or a fault. One request at a
// time; memory returns exactly one mem_valid per mem_req.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_BITS    = 43,
    parameter int PAGE_SHIFT = 13,
    parameter int IDX_BITS   = 10,
    parameter int LEVELS     = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [63:0] req_vaddr,
    input  logic [1:0]  req_acc,
    input  logic        req_user,
    input  logic [63:0] req_ptbr,
    output logic        busy,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_valid,
    input  logic [63:0] mem_rdata,
    output logic        done,
    output logic        ok,
    output logic [63:0] paddr,
    output logic [2:0]  perm,
    output logic [2:0]  fault_code,
    output logic [63:0] fault_va,
    output logic [1:0]  fault_acc
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);
    localparam logic [63:0] OFS_MASK = (64'd1 << PAGE_SHIFT) - 64'd1;

    typedef enum logic [1:0] {ST_IDLE, ST_SCREEN, ST_ISSUE, ST_WAIT} st_e;

    st_e              state;
    logic [63:0]      va_q;
    logic [63:0]      base_q;
    logic [1:0]       acc_q;
    logic             user_q;
    logic [LVL_W-1:0] lvl_q;

    logic             sign_bad, super_hit;
    logic [63:0]      super_pa;
    flt_e             leaf_code;
    logic [2:0]       leaf_perm;
    logic [63:0]      frame;

    logic             fin_go;
    flt_e             fin_code;
    logic [63:0]      fin_pa;
    logic [2:0]       fin_perm;

    logic [IDX_BITS-1:0] lvl_idx [LEVELS];

    pt_addr_screen #(.VA_BITS(VA_BITS)) screen_i (
        .va        (va_q),
        .sign_bad  (sign_bad),
        .super_hit (super_hit),
        .super_pa  (super_pa)
    );

    pt_leaf_eval leaf_i (
        .pte  (mem_rdata),
        .user (user_q),
        .need (need_of(acc_q)),
        .code (leaf_code),
        .perm (leaf_perm)
    );

    // Per-level table index slices, outermost level first
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        localparam int SH = PAGE_SHIFT + IDX_BITS * (LEVELS - 1 - g);
        assign lvl_idx[g] = va_q[SH +: IDX_BITS];
    end

    // Frame address carried in the upper half of an entry
    always_comb frame = 64'(mem_rdata[63:32]) << PAGE_SHIFT;

    // Read port drive: one-cycle request at the current level's entry
    always_comb begin
        mem_req  = (state == ST_ISSUE);
        mem_addr = base_q + (64'(lvl_idx[lvl_q]) << 3);
    end

    always_comb busy = (state != ST_IDLE);

    // Decide whether this cycle ends the request and with what result
    always_comb begin
        fin_go   = 1'b0;
        fin_code = FLT_NONE;
        fin_pa   = 64'd0;
        fin_perm = 3'b000;
        if (state == ST_SCREEN) begin
            if (sign_bad) begin
                fin_go   = 1'b1;
                fin_code = FLT_ACV;
            end else if (super_hit) begin
                fin_go = 1'b1;
                if (user_q) begin
                    fin_code = FLT_ACV;
                end else begin
                    fin_pa   = super_pa;
                    fin_perm = 3'b111;
                end
            end
        end else if (state == ST_WAIT && mem_valid) begin
            if (!mem_rdata[E_VALID]) begin
                fin_go   = 1'b1;
                fin_code = FLT_TNV;
            end else if (lvl_q != LAST_LVL) begin
                if (!mem_rdata[E_RD_LO]) begin
                    fin_go   = 1'b1;
                    fin_code = FLT_ACV;
                end
            end else begin
                fin_go   = 1'b1;
                fin_code = leaf_code;
                if (leaf_code == FLT_NONE) begin
                    fin_pa   = frame | (va_q & OFS_MASK);
                    fin_perm = leaf_perm;
                end
            end
        end
    end

    // Sequencer: accept, screen, issue and wait per level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            va_q   <= 64'd0;
            base_q <= 64'd0;
            acc_q  <= 2'd0;
            user_q <= 1'b0;
            lvl_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    base_q <= req_ptbr;
                    acc_q  <= req_acc;
                    user_q <= req_user;
                    lvl_q  <= '0;
                    state  <= ST_SCREEN;
                end
                ST_SCREEN: state <= fin_go ? ST_IDLE : ST_ISSUE;
                ST_ISSUE:  state <= ST_WAIT;
                ST_WAIT: if (mem_valid) begin
                    if (fin_go) begin
                        state <= ST_IDLE;
                    end else begin
                        base_q <= frame;
                        lvl_q  <= lvl_q + 1'b1;
                        state  <= ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result registers: pulse done and hold the result until the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            ok         <= 1'b0;
            paddr      <= 64'd0;
            perm       <= 3'b000;
            fault_code <= 3'd0;
            fault_va   <= 64'd0;
            fault_acc  <= 2'b00;
        end else begin
            done <= fin_go;
            if (fin_go) begin
                ok         <= (fin_code == FLT_NONE);
                paddr      <= fin_pa;
                perm       <= fin_perm;
                fault_code <= fin_code;
                fault_va   <= (fin_code == FLT_NONE) ? 64'd0 : va_q;
                if (fin_code == FLT_NONE)  fault_acc <= 2'b00;
                else if (acc_q == ACC_EX)  fault_acc <= 2'b11;
                else if (acc_q == ACC_WR)  fault_acc <= 2'b01;
                else                       fault_acc <= 2'b00;
            end
        end
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and result checker for pt_walker, attached through bind.
// Captures each accepted request from the ports and relates it to the
// completion seen later.
module pt_walker_chk #(
    parameter int VA_BITS = 43
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [63:0] req_vaddr,
    input logic [1:0]  req_acc,
    input logic        req_user,
    input logic        busy,
    input logic        mem_req,
    input logic        done,
    input logic        ok,
    input logic [2:0]  perm,
    input logic [2:0]  fault_code
);
    logic [63:0] cap_va;
    logic [2:0]  cap_need;
    logic        cap_user;
    logic        cap_sign_bad;
    logic        cap_super;

    // Remember the request that was accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_va   <= 64'd0;
            cap_need <= 3'b000;
            cap_user <= 1'b0;
        end else if (req_valid && !busy) begin
            cap_va   <= req_vaddr;
            cap_user <= req_user;
            case (req_acc)
                2'd0:    cap_need <= 3'b001;
                2'd1:    cap_need <= 3'b010;
                2'd2:    cap_need <= 3'b100;
                default: cap_need <= 3'b000;
            endcase
        end
    end

    always_comb begin
        cap_sign_bad = ($signed(cap_va) >>> VA_BITS) != ($signed(cap_va) >>> 63);
        cap_super    = cap_va[63] && cap_va[42] && !cap_va[41];
    end

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R12
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_MEMREQ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R13
    AST_SIGN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_sign_bad) |-> (!ok && fault_code == 3'd1)); // R1
    AST_SUPER_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cap_super && !cap_sign_bad) |-> !mem_req); // R2
    AST_SUPER_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_super && cap_user && !cap_sign_bad) |-> !ok); // R3
    AST_NEED_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && cap_need != 3'b000) |-> ((perm & cap_need) != 3'b000)); // R8
endmodule

bind pt_walker pt_walker_chk #(.VA_BITS(VA_BITS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_acc    (req_acc),
    .req_user   (req_user),
    .busy       (busy),
    .mem_req    (mem_req),
    .done       (done),
    .ok         (ok),
    .perm       (perm),
    .fault_code (fault_code)
);

// File: tb/pt_walker_tb_top.sv
// Directed bench for pt_walker: a sparse table memory with settable
// latency, one task per scenario, each checking its own results.
module pt_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = 64'd0;
    logic [1:0]  req_acc = 2'd0;
    logic        req_user = 1'b0;
    logic [63:0] req_ptbr = 64'h10000;
    logic        busy, mem_req, done, ok;
    logic [63:0] mem_addr, paddr, fault_va;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_rdata = 64'd0;
    logic [2:0]  perm, fault_code;
    logic [1:0]  fault_acc;

    int checks = 0;
    int errors = 0;
    int lat_cfg = 0;
    int n_reads = 0;
    int cnt = 0;
    logic        pending = 1'b0;
    logic [63:0] pend_addr = 64'd0;
    logic [63:0] mem_tbl [logic [63:0]];

    localparam logic [63:0] PTBR = 64'h10000;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user), .req_ptbr(req_ptbr),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done), .ok(ok),
        .paddr(paddr), .perm(perm), .fault_code(fault_code),
        .fault_va(fault_va), .fault_acc(fault_acc)
    );

    always #2 clk = ~clk;

    function automatic logic [63:0] rd(input logic [63:0] a);
        if (mem_tbl.exists(a)) return mem_tbl[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] mkva(input int l1, input int l2, input int l3,
                                         input int ofs);
        return (64'(l1) << 33) | (64'(l2) << 23) | (64'(l3) << 13) | 64'(ofs);
    endfunction

    // Memory model: one response per request after lat_cfg extra cycles
    always @(posedge clk) begin
        mem_valid <= 1'b0;
        if (mem_req) begin
            pending   <= 1'b1;
            pend_addr <= mem_addr;
            cnt       <= lat_cfg;
            n_reads   <= n_reads + 1;
        end else if (pending) begin
            if (cnt == 0) begin
                mem_valid <= 1'b1;
                mem_rdata <= rd(pend_addr);
                pending   <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Issue one request and wait for its done pulse; returns reads used
    task automatic xlate(input logic [63:0] va, input logic [1:0] acc,
                         input logic usr, output int reads);
        int start;
        @(negedge clk);
        start     = n_reads;
        req_vaddr = va;
        req_acc   = acc;
        req_user  = usr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        reads = n_reads - start;
    endtask

    task automatic expect_fault(input string rq, input logic [63:0] va,
                                input logic [1:0] acc, input logic usr,
                                input logic [2:0] code, input int exp_reads);
        int reads;
        logic [1:0] ind;
        xlate(va, acc, usr, reads);
        ind = (acc == 2'd2) ? 2'b11 : (acc == 2'd1) ? 2'b01 : 2'b00;
        chk(rq, {63'd0, ok}, 64'd0);
        chk(rq, {61'd0, fault_code}, {61'd0, code});
        chk(rq, fault_va, va);
        chk(rq, {62'd0, fault_acc}, {62'd0, ind});
        chk(rq, paddr | {61'd0, perm}, 64'd0);
        chk(rq, 64'(reads), 64'(exp_reads));
    endtask

    task automatic expect_ok(input string rq, input logic [63:0] va,
                             input logic [1:0] acc, input logic usr,
                             input logic [63:0] pa, input logic [2:0] pm,
                             input int exp_reads);
        int reads;
        xlate(va, acc, usr, reads);
        chk(rq, {63'd0, ok}, 64'd1);
        chk(rq, {61'd0, fault_code}, 64'd0);
        chk(rq, paddr, pa);
        chk(rq, {61'd0, perm}, {61'd0, pm});
        chk(rq, 64'(reads), 64'(exp_reads));
    endtask

    task automatic t_reset;
        chk("R12 reset busy", {63'd0, busy}, 64'd0);
        chk("R12 reset done", {63'd0, done}, 64'd0);
        chk("R12 reset mem_req", {63'd0, mem_req}, 64'd0);
    endtask

    task automatic t_sign;
        expect_fault("R1 sign", 64'h0000_1000_0000_0000, 2'd1, 1'b0, 3'd1, 0);
        // R1 boundary: bit 42 alone is allowed through to the walk
        expect_fault("R1 bit42 walk", 64'h0000_0400_0000_0000, 2'd0, 1'b0, 3'd2, 1);
    endtask

    task automatic t_super;
        expect_ok("R2 superpage", 64'hFFFF_FD12_3456_789A, 2'd1, 1'b0,
                  64'h0000_0812_3456_789A, 3'b111, 0);
        expect_fault("R3 super user", 64'hFFFF_FD12_3456_789A, 2'd0, 1'b1, 3'd1, 0);
    endtask

    task automatic t_walk_ok;
        lat_cfg = 0;
        expect_ok("R4 R7 kernel read", mkva(1, 2, 3, 'h123), 2'd0, 1'b0,
                  64'h0EEE_E123, 3'b111, 3);
        lat_cfg = 6;
        expect_ok("R7 R13 user read slow", mkva(1, 2, 3, 'h1FFF), 2'd0, 1'b1,
                  64'h0EEE_FFFF, 3'b101, 3);
        lat_cfg = 1;
    endtask

    task automatic t_rights;
        expect_fault("R8 user write", mkva(1, 2, 3, 0), 2'd1, 1'b1, 3'd1, 3);
        expect_fault("R9 fault-on write", mkva(1, 2, 4, 8), 2'd1, 1'b0, 3'd4, 3);
        expect_ok("R9 read past fow", mkva(1, 2, 4, 8), 2'd0, 1'b0,
                  64'h0EEE_E008, 3'b101, 3);
        expect_fault("R9 R11 fault-on exec", mkva(1, 2, 5, 4), 2'd2, 1'b0, 3'd5, 3);
        expect_ok("R9 read past foe", mkva(1, 2, 5, 4), 2'd0, 1'b0,
                  64'h0EEE_E004, 3'b001, 3);
        expect_ok("R10 probe empty", mkva(1, 2, 4, 0), 2'd3, 1'b1,
                  64'h0EEE_E000, 3'b000, 3);
    endtask

    task automatic t_invalid;
        expect_fault("R5 l1 invalid", mkva(3, 0, 0, 0), 2'd0, 1'b0, 3'd2, 1);
        expect_fault("R5 l2 invalid", mkva(1, 7, 0, 0), 2'd0, 1'b0, 3'd2, 2);
        expect_fault("R5 leaf invalid", mkva(1, 2, 6, 0), 2'd0, 1'b0, 3'd2, 3);
        expect_fault("R6 l1 no kre", mkva(2, 0, 0, 0), 2'd0, 1'b0, 3'd1, 1);
    endtask

    // R12: a request arriving mid-walk must not disturb the current one
    task automatic t_ignore;
        int start;
        lat_cfg = 4;
        @(negedge clk);
        start     = n_reads;
        req_vaddr = mkva(1, 2, 3, 'h40);
        req_acc   = 2'd0;
        req_user  = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 busy after accept", {63'd0, busy}, 64'd1);
        repeat (3) @(negedge clk);
        req_vaddr = 64'hFFFF_FD00_0000_0000;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk("R12 ignored paddr", paddr, 64'h0EEE_E040);
        chk("R12 ignored reads", 64'(n_reads - start), 64'd3);
        chk("R12 busy at done", {63'd0, busy}, 64'd0);
        repeat (3) @(negedge clk);
        chk("R12 no second done", {63'd0, done}, 64'd0);
        lat_cfg = 1;
    endtask

    initial begin
        mem_tbl[64'h10008] = 64'h0000_0020_0000_0101;
        mem_tbl[64'h10010] = 64'h0000_0020_0000_0001;
        mem_tbl[64'h40010] = 64'h0000_0030_0000_0101;
        mem_tbl[64'h60018] = 64'h0000_7777_0000_1301;
        mem_tbl[64'h60020] = 64'h0000_7777_0000_1105;
        mem_tbl[64'h60028] = 64'h0000_7777_0000_0109;
        req_ptbr = PTBR;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_sign();
        t_super();
        t_walk_ok();
        t_rights();
        t_invalid();
        t_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule